// File: doc/BRIEF.md
# Round-Robin Bus Arbiter with Idle Tracking

This block is the central arbiter of a shared parallel bus that carries up to seven masters. Each master has a request line and a grant line of its own, both active low. A master holds its request low for as long as it has a transfer pending. The arbiter turns on at most one grant at a time. It picks the winner in rotating order, so every requester is served in turn.

The arbiter also watches the two shared active-low bus-control lines: the frame line and the initiator-ready line. The bus counts as free only when both lines are sampled high on the same rising edge. A grant may be handed out while another master still owns the bus. The granted master then waits until the `bus_idle` output is high before it starts its own transaction.

When a grant moves from one master to another, at least one clock passes with no grant active. If the granted master withdraws its request before it starts, the grant is removed and arbitration runs again on the following clock.

Top module: `busarb_core`

## Requirements
- R1: While `rst_n` is low, every bit of `gnt_n` is 1 and `bus_idle` is 0. After reset the rotating search starts at master 0.
- R2: At most one bit of `gnt_n` is 0 on any clock.
- R3: A grant is issued only on an edge where no grant is active. It goes to the first master, searching upward from the master after the one granted last, whose `req_n` bit is 0 at that edge. Bit i of each vector belongs to master i.
- R4: An active grant stays on the same master for as long as that master's `req_n` bit is sampled 0.
- R5: When the granted master's `req_n` bit is sampled 1, all grants are off after that edge. A new grant can appear no earlier than the edge after that.
- R6: When no `req_n` bit is 0 and no grant is active, all grants stay off.
- R7: `bus_idle` is 1 in the cycle after an edge at which `frame_n` and `irdy_n` are both 1. Otherwise it is 0.
- R8: The rotating search wraps: after master 6 has been granted, master 0 comes first in the next search.
- R9: The grant decision does not depend on bus activity. A grant may be issued while `frame_n` or `irdy_n` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_n | input | 7 | Per-master request, active low; bit i is master i |
| frame_n | input | 1 | Shared frame line, active low |
| irdy_n | input | 1 | Shared initiator-ready line, active low |
| gnt_n | output | 7 | Per-master grant, active low; bit i is master i |
| bus_idle | output | 1 | High in the cycle after the bus was sampled free |

## Verification
The bench walks through these cases:
- **Hand-off gap.** A request is dropped while other masters still wait. A design that moved the grant straight across would show a second grant with no empty cycle in between.
- **Rotation.** Every master requests at once, then each drops out in turn. This exposes a search that restarts at master 0 instead of after the last winner, and a wrap error from master 6 back to master 0.
- **Grant while busy.** A grant is issued while the bus is still busy. This catches a design that wrongly waits for idle before granting.
- **Idle detection.** The bench drives the bus with only one of the two control lines high. A design that accepted either line alone as idle would raise `bus_idle` here.
- **Reset mid-grant.** Reset is applied while a grant is active. This confirms that the grant is cleared and that the rotation pointer returns to its reset position.

// File: rtl/busarb_pkg.sv
package busarb_pkg;
    typedef enum logic {
        ARB_OPEN = 1'b0,
        ARB_HELD = 1'b1
    } arb_phase_e;
endpackage

// File: rtl/busarb_rr_pick.sv
module busarb_rr_pick #(
    parameter int NUM_M = 7,
    localparam int IW = (NUM_M > 1) ? $clog2(NUM_M) : 1
) (
    input  logic [NUM_M-1:0] req,
    input  logic [IW-1:0]    last,
    output logic             found,
    output logic [IW-1:0]    pick
);
    int pos;

    always_comb begin
        found = 1'b0;
        pick  = '0;
        pos   = 0;
        for (int off = 1; off <= NUM_M; off++) begin
            pos = int'(last) + off;
            if (pos >= NUM_M) begin
                pos = pos - NUM_M;
            end
            if (!found && req[pos]) begin
                found = 1'b1;
                pick  = IW'(pos);
            end
        end
    end
endmodule

// File: rtl/busarb_idle_mon.sv
module busarb_idle_mon (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_n,
    input  logic irdy_n,
    output logic idle
);
    logic idle_d, idle_q;

    always_comb begin
        idle_d = frame_n & irdy_n;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idle_q <= 1'b0;
        end else begin
            idle_q <= idle_d;
        end
    end

    assign idle = idle_q;

    // R7: free only when both control lines were high at the previous edge
    assert_idle_both_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_n || !irdy_n) |=> !idle);
endmodule

// File: rtl/busarb_core.sv
module busarb_core #(
    parameter int NUM_M = 7,
    localparam int IW = (NUM_M > 1) ? $clog2(NUM_M) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NUM_M-1:0] req_n,
    input  logic             frame_n,
    input  logic             irdy_n,
    output logic [NUM_M-1:0] gnt_n,
    output logic             bus_idle
);
    import busarb_pkg::*;

    typedef struct packed {
        arb_phase_e    phase;
        logic [IW-1:0] owner;
        logic [IW-1:0] last;
    } arb_state_t;

    arb_state_t      st_d, st_q;
    logic [NUM_M-1:0] req_act;
    logic [NUM_M-1:0] grant_vec;
    logic             pick_found;
    logic [IW-1:0]    pick_idx;

    assign req_act = ~req_n;

    busarb_rr_pick #(.NUM_M(NUM_M)) u_pick (
        .req   (req_act),
        .last  (st_q.last),
        .found (pick_found),
        .pick  (pick_idx)
    );

    busarb_idle_mon u_idle (
        .clk     (clk),
        .rst_n   (rst_n),
        .frame_n (frame_n),
        .irdy_n  (irdy_n),
        .idle    (bus_idle)
    );

    always_comb begin
        st_d = st_q;
        if (st_q.phase == ARB_HELD) begin
            if (!req_act[st_q.owner]) begin
                st_d.phase = ARB_OPEN;
            end
        end else if (pick_found) begin
            st_d.phase = ARB_HELD;
            st_d.owner = pick_idx;
            st_d.last  = pick_idx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.phase <= ARB_OPEN;
            st_q.owner <= '0;
            st_q.last  <= IW'(NUM_M - 1);
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar g = 0; g < NUM_M; g++) begin : g_grant
        assign grant_vec[g] = (st_q.phase == ARB_HELD) && (st_q.owner == IW'(g));
    end

    assign gnt_n = ~grant_vec;

    assert_one_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~gnt_n));

    assert_grant_to_requester_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_vec != '0 && $past(grant_vec) == '0) |-> (($past(req_act) & grant_vec) != '0));

    assert_grant_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((grant_vec & req_act) != '0) |=> (grant_vec == $past(grant_vec)));

    assert_drop_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_vec != '0 && (grant_vec & req_act) == '0) |=> (grant_vec == '0));

    assert_handoff_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_vec != '0) |=> (grant_vec == '0 || grant_vec == $past(grant_vec)));

    assert_no_req_no_grant_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_act == '0 && grant_vec == '0) |=> (grant_vec == '0));

    assert_idle_seen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_n && irdy_n) |=> bus_idle);
endmodule

// File: tb/busarb_core_tb_top.sv
module busarb_core_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NM = 7;
    localparam int NVEC = 13;

    // entry: {req (active high), frame_n, irdy_n, expected grant (active high), expected idle}
    localparam logic [16:0] VEC [NVEC] = '{
        17'b0000000_1_1_0000000_1,
        17'b0000101_1_1_0000001_1,
        17'b0000101_0_1_0000001_0,
        17'b0000100_0_0_0000000_0,
        17'b0000100_1_0_0000100_0,
        17'b0000100_1_1_0000100_1,
        17'b1000001_1_1_0000000_1,
        17'b1000001_1_1_1000000_1,
        17'b0000001_1_1_0000000_1,
        17'b0000001_1_1_0000001_1,
        17'b0000000_1_1_0000000_1,
        17'b0000000_1_1_0000000_1,
        17'b0000010_1_1_0000010_1
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NM-1:0] req_n = '1;
    logic          frame_n = 1'b1;
    logic          irdy_n = 1'b1;
    logic [NM-1:0] gnt_n;
    logic          bus_idle;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    busarb_core #(.NUM_M(NM)) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_n    (req_n),
        .frame_n  (frame_n),
        .irdy_n   (irdy_n),
        .gnt_n    (gnt_n),
        .bus_idle (bus_idle)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    initial begin
        logic [NM-1:0] r;
        repeat (3) step();
        check("R1 reset grants", {1'b0, ~gnt_n}, 8'h00);
        check("R1 reset idle", {7'b0, bus_idle}, 8'h00);
        rst_n = 1'b1;

        for (int k = 0; k < NVEC; k++) begin
            req_n   = ~VEC[k][16:10];
            frame_n = VEC[k][9];
            irdy_n  = VEC[k][8];
            step();
            // R2 R3 R4 R5 R6 R8 R9 grant, R7 idle
            check($sformatf("R3/R4/R5/R6/R8/R9 grant vec %0d", k), {1'b0, ~gnt_n}, {1'b0, VEC[k][7:1]});
            check($sformatf("R7 idle vec %0d", k), {7'b0, bus_idle}, {7'b0, VEC[k][0]});
        end

        rst_n = 1'b0;
        step();
        check("R1 reset mid-grant", {1'b0, ~gnt_n}, 8'h00);
        rst_n = 1'b1;
        req_n = ~7'b0001001;
        step();
        check("R1 pointer restart", {1'b0, ~gnt_n}, 8'h01);

        r = '1;
        req_n = ~r;
        step();
        check("R4 hold with all requesting", {1'b0, ~gnt_n}, 8'h01);
        for (int k = 0; k < NM; k++) begin
            r[k] = 1'b0;
            req_n = ~r;
            step();
            check($sformatf("R5 gap after master %0d", k), {1'b0, ~gnt_n}, 8'h00);
            if (k < NM - 1) begin
                step();
                check($sformatf("R3 rotate to master %0d", k + 1), {1'b0, ~gnt_n}, 8'(1 << (k + 1)));
            end
        end
        step();
        check("R6 none requesting", {1'b0, ~gnt_n}, 8'h00);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule